// File: doc/BRIEF.md
# Pipelined CORDIC Sine Generator

This block is the sine stage of a direct digital synthesiser. A phase word comes in. Its two top bits pick the quadrant, and the angle is folded into the half-turn centred on zero. A chain of rotation-mode CORDIC stages, one stage per data bit, then drives the residual angle towards zero. Each stage shifts the X and Y terms arithmetically before it adds or subtracts them, so only the stage sums are registered. The arctangent step for each stage and the start value of X, which pre-compensates the CORDIC gain, are computed at elaboration from the configured widths.

A sideband word enters with each phase and travels through the same registers, so it leaves aligned with its sine sample. The whole pipeline advances only in cycles where the converter-side step enable is high. A final stage restores the sign from the fold and adapts the internal sample to the requested output width. A narrower output is rounded. A wider output is shifted left and padded with zeros.

Top module: `cordic_sine_core`

## Requirements
- R1: `PHASE_W` and `DATA_W` are parameters, each legal from 8 to 24. A build with a 12-bit phase and a 14-bit core meets R4 for its own widths.
- R2: A phase accepted on an enabled clock edge produces its sample on the (`DATA_W`+2)-th enabled edge, counting the accepting edge as the first.
- R3: `side_o` carries the `side_i` word that was accepted with the phase whose sine is on `sine_o`.
- R4: `sine_o` is two's complement. It lies within a width-dependent tolerance of (2^(`DATA_W`-1)-1)·2^(`OUT_W`-`DATA_W`)·sin(2π·phase/2^`PHASE_W`), with that ideal clamped to ±(2^(`OUT_W`-1)-1).
- R5: Phase bits [`PHASE_W`-1:`PHASE_W`-2] select the quadrant (00 = 0°, 01 = 90°, 10 = 180°, 11 = 270° onward). After folding, the angle entering the rotations lies in [-90°, +90°). The quarter points and their neighbours follow R4.
- R6: When `OUT_W` < `DATA_W`, the dropped bits round the kept bits. The error is at most 0.75 output LSB from the ideal of R4.
- R7: When `OUT_W` > `DATA_W`, the low `OUT_W`-`DATA_W` bits of `sine_o` are zero.
- R8: In a cycle where `step_en` is low, no pipeline register changes, and `sine_o` and `side_o` hold their values.
- R9: While `rst_n` is low, `sine_o` and `side_o` are cleared to zero at the clock edge. The rotation data path has no reset.
- R10: The gain start value keeps the output from overflowing. `sine_o` never takes the most negative code.
- R11: At the last stage, the magnitude of the residual angle is no larger than the last table angle plus `DATA_W`+2 angle guard LSBs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| step_en | input | 1 | Converter-side enable; the pipeline advances only when high |
| phase_i | input | PHASE_W | Phase word, a full turn is 2^PHASE_W |
| side_i | input | SIDE_W | Sideband word carried with the phase |
| sine_o | output | OUT_W | Signed sine sample |
| side_o | output | SIDE_W | Sideband word aligned with `sine_o` |

## Verification
The bench aims at the quarter points 0, 90, 180 and 270 degrees and their one-LSB neighbours. A wrong quadrant fold shows there as a sign flip or as a sample mirrored about the wrong axis. Full-scale peaks expose a wrong gain start value, which would either wrap to a large sample of the wrong sign or fall short of full scale. Stall gaps and a per-sample sideband tag expose a latency that is off by one, or a pipeline that keeps moving while the enable is low. A narrow build and a wide build catch truncation in place of rounding and stray bits below the left shift.

// File: rtl/cordic_sine_pkg.sv
`timescale 1ns / 1ps
// Package: constants and elaboration-time math shared by the CORDIC sine core.
// Assumes callers pass widths in the legal range 8..24.
package cordic_sine_pkg;

    // Fraction bits appended below the phase LSB in the residual angle.
    localparam int ZG  = 4;
    // Fraction bits appended below the sample LSB in the X/Y data path.
    localparam int XYG = 2;

    localparam real TWO_PI = 6.283185307179586;

    // Arctangent of 2^-idx in units where a full turn equals 2^frac_bits.
    function automatic int atan_units(input int idx, input int frac_bits);
        real ang;
        ang = $atan(2.0 ** (-idx));
        return $rtoi(ang * (2.0 ** frac_bits) / TWO_PI + 0.5);
    endfunction

    // Start value of X: full scale less two LSB, times the inverse CORDIC gain.
    function automatic int gain_seed(input int dw, input int iters);
        real k;
        k = 1.0;
        for (int i = 0; i < iters; i++) begin
            k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return $rtoi(k * (2.0 ** (dw - 1) - 2.0) * (2.0 ** XYG));
    endfunction

    // Largest residual angle expected after the last rotation.
    function automatic int resid_limit(input int pw, input int dw);
        return atan_units(dw - 1, pw + ZG) + dw + 2;
    endfunction

endpackage

// File: rtl/cordic_phase_fold.sv
`timescale 1ns / 1ps
// Module: first pipeline stage. Folds the phase into [-90, +90) degrees using
// the two top phase bits, records whether the result must be negated, and
// loads X with the gain-compensated start value and Y with zero.
// Assumes PHASE_W >= 3. The data registers carry no reset by design.
module cordic_phase_fold #(
    parameter int PHASE_W = 16,
    parameter int XYW     = 19,
    parameter int ZW      = 21,
    parameter int SIDE_W  = 8,
    parameter int SEED    = 0
) (
    input  logic                     clk,
    input  logic                     step_en,
    input  logic [PHASE_W-1:0]       phase_i,
    input  logic [SIDE_W-1:0]        side_i,
    output logic signed [XYW-1:0]    x_o,
    output logic signed [XYW-1:0]    y_o,
    output logic signed [ZW-1:0]     z_o,
    output logic                     neg_o,
    output logic [SIDE_W-1:0]        side_o
);
    import cordic_sine_pkg::*;

    logic                 flip;
    logic [PHASE_W-1:0]   folded;
    logic signed [ZW-1:0] z_start;

    // Quadrants 01 and 10 are moved by half a turn and marked for negation.
    always_comb begin
        flip    = phase_i[PHASE_W-1] ^ phase_i[PHASE_W-2];
        folded  = {phase_i[PHASE_W-1] ^ flip, phase_i[PHASE_W-2:0]};
        z_start = {folded[PHASE_W-1], folded, {ZG{1'b0}}};
    end

    // Register the folded angle and start vector when the converter steps.
    always_ff @(posedge clk) begin
        if (step_en) begin
            x_o    <= XYW'(SEED);
            y_o    <= '0;
            z_o    <= z_start;
            neg_o  <= flip;
            side_o <= side_i;
        end
    end

endmodule

// File: rtl/cordic_micro_rotation.sv
`timescale 1ns / 1ps
// Module: one rotation-mode CORDIC iteration. X and Y are shifted right
// arithmetically by STAGE first; the shifted terms are then added or
// subtracted, and only the sums are registered. The direction follows the
// sign of the residual angle. The angle step is computed from PHASE_W.
module cordic_micro_rotation #(
    parameter int STAGE   = 0,
    parameter int PHASE_W = 16,
    parameter int XYW     = 19,
    parameter int ZW      = 21,
    parameter int SIDE_W  = 8
) (
    input  logic                  clk,
    input  logic                  step_en,
    input  logic signed [XYW-1:0] x_i,
    input  logic signed [XYW-1:0] y_i,
    input  logic signed [ZW-1:0]  z_i,
    input  logic                  neg_i,
    input  logic [SIDE_W-1:0]     side_i,
    output logic signed [XYW-1:0] x_o,
    output logic signed [XYW-1:0] y_o,
    output logic signed [ZW-1:0]  z_o,
    output logic                  neg_o,
    output logic [SIDE_W-1:0]     side_o
);
    import cordic_sine_pkg::*;

    localparam int ANGLE = atan_units(STAGE, PHASE_W + ZG);
    localparam logic signed [ZW-1:0] STEP = ZW'(ANGLE);

    logic signed [XYW-1:0] x_sh;
    logic signed [XYW-1:0] y_sh;
    logic                  down;

    // Shift the operands before the add/subtract; decide rotation sense.
    always_comb begin
        x_sh = x_i >>> STAGE;
        y_sh = y_i >>> STAGE;
        down = ~z_i[ZW-1];
    end

    // Register the rotated vector, the updated residual and the sideband.
    always_ff @(posedge clk) begin
        if (step_en) begin
            x_o    <= down ? (x_i - y_sh) : (x_i + y_sh);
            y_o    <= down ? (y_i + x_sh) : (y_i - x_sh);
            z_o    <= down ? (z_i - STEP) : (z_i + STEP);
            neg_o  <= neg_i;
            side_o <= side_i;
        end
    end

endmodule

// File: rtl/cordic_sample_shape.sv
`timescale 1ns / 1ps
// Module: last pipeline stage. Restores the sign removed by the quadrant fold,
// drops the guard bits with round-half-up, clamps to a symmetric range, and
// adapts to OUT_W: rounding when narrower, zero-filled left shift when wider.
// Only this output register is reset.
module cordic_sample_shape #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 16,
    parameter int XYW    = 19,
    parameter int SIDE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic signed [XYW-1:0]    y_i,
    input  logic                     neg_i,
    input  logic [SIDE_W-1:0]        side_i,
    output logic signed [OUT_W-1:0]  sine_o,
    output logic [SIDE_W-1:0]        side_o
);
    import cordic_sine_pkg::*;

    localparam int KW   = (OUT_W <= DATA_W) ? OUT_W : DATA_W;
    localparam int DROP = XYG + DATA_W - KW;
    localparam int VW   = XYW + 1;
    localparam logic signed [VW-1:0] HALF  = VW'(1) <<< (DROP - 1);
    localparam logic signed [VW-1:0] K_MAX = VW'((1 << (KW - 1)) - 1);
    localparam logic signed [VW-1:0] K_MIN = -K_MAX;

    logic signed [VW-1:0]    signed_v;
    logic signed [VW-1:0]    rounded;
    logic signed [KW-1:0]    kept;
    logic signed [OUT_W-1:0] shaped;

    // Apply the fold sign, round away the dropped bits and clamp.
    always_comb begin
        signed_v = {y_i[XYW-1], y_i};
        if (neg_i) begin
            signed_v = -signed_v;
        end
        rounded = (signed_v + HALF) >>> DROP;
        if (rounded > K_MAX) begin
            kept = K_MAX[KW-1:0];
        end else if (rounded < K_MIN) begin
            kept = K_MIN[KW-1:0];
        end else begin
            kept = rounded[KW-1:0];
        end
    end

    generate
        if (OUT_W > DATA_W) begin : g_widen
            // Wider output: shift left and pad with zeros.
            always_comb shaped = {kept, {(OUT_W - DATA_W){1'b0}}};
        end else begin : g_keep
            // Narrower or equal output: the rounded value is the sample.
            always_comb shaped = kept;
        end
    endgenerate

    // Output register: cleared by reset, otherwise loaded on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sine_o <= '0;
            side_o <= '0;
        end else if (step_en) begin
            sine_o <= shaped;
            side_o <= side_i;
        end
    end

endmodule

// File: rtl/cordic_sine_core.sv
`timescale 1ns / 1ps
// Module: top of the pipelined CORDIC sine generator. One fold stage,
// DATA_W rotation stages and one output stage, so the latency is DATA_W+2
// enabled cycles. Assumes PHASE_W and DATA_W in 8..24 and
// OUT_W >= 2.
module cordic_sine_core #(
    parameter int PHASE_W = 16,
    parameter int DATA_W  = 16,
    parameter int OUT_W   = 16,
    parameter int SIDE_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic [PHASE_W-1:0]       phase_i,
    input  logic [SIDE_W-1:0]        side_i,
    output logic signed [OUT_W-1:0]  sine_o,
    output logic [SIDE_W-1:0]        side_o
);
    import cordic_sine_pkg::*;

    localparam int N_ITER = DATA_W;
    localparam int XYW    = DATA_W + 1 + XYG;
    localparam int ZW     = PHASE_W + 1 + ZG;
    localparam int SEED   = gain_seed(DATA_W, N_ITER);

    logic signed [XYW-1:0] x_pipe    [0:N_ITER];
    logic signed [XYW-1:0] y_pipe    [0:N_ITER];
    logic signed [ZW-1:0]  z_pipe    [0:N_ITER];
    logic                  neg_pipe  [0:N_ITER];
    logic [SIDE_W-1:0]     side_pipe [0:N_ITER];
    logic signed [ZW-1:0]  fold_z;
    logic signed [ZW-1:0]  last_z;

    // Expose the first and last residual angles to the bound checker.
    always_comb begin
        fold_z = z_pipe[0];
        last_z = z_pipe[N_ITER];
    end

    cordic_phase_fold #(
        .PHASE_W(PHASE_W), .XYW(XYW), .ZW(ZW), .SIDE_W(SIDE_W), .SEED(SEED)
    ) u_fold (
        .clk(clk), .step_en(step_en), .phase_i(phase_i), .side_i(side_i),
        .x_o(x_pipe[0]), .y_o(y_pipe[0]), .z_o(z_pipe[0]),
        .neg_o(neg_pipe[0]), .side_o(side_pipe[0])
    );

    generate
        for (genvar g = 0; g < N_ITER; g++) begin : g_rot
            cordic_micro_rotation #(
                .STAGE(g), .PHASE_W(PHASE_W), .XYW(XYW), .ZW(ZW), .SIDE_W(SIDE_W)
            ) u_rot (
                .clk(clk), .step_en(step_en),
                .x_i(x_pipe[g]), .y_i(y_pipe[g]), .z_i(z_pipe[g]),
                .neg_i(neg_pipe[g]), .side_i(side_pipe[g]),
                .x_o(x_pipe[g+1]), .y_o(y_pipe[g+1]), .z_o(z_pipe[g+1]),
                .neg_o(neg_pipe[g+1]), .side_o(side_pipe[g+1])
            );
        end
    endgenerate

    cordic_sample_shape #(
        .DATA_W(DATA_W), .OUT_W(OUT_W), .XYW(XYW), .SIDE_W(SIDE_W)
    ) u_shape (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .y_i(y_pipe[N_ITER]), .neg_i(neg_pipe[N_ITER]), .side_i(side_pipe[N_ITER]),
        .sine_o(sine_o), .side_o(side_o)
    );

endmodule

// File: rtl/cordic_sine_core_chk.sv
`timescale 1ns / 1ps
// Module: assertion checker bound to cordic_sine_core. A local fill counter
// gates the properties that need a primed pipeline.
module cordic_sine_core_chk #(
    parameter int PHASE_W = 16,
    parameter int DATA_W  = 16,
    parameter int OUT_W   = 16,
    parameter int SIDE_W  = 8,
    parameter int ZW      = 21
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     step_en,
    input logic signed [OUT_W-1:0]  sine_o,
    input logic [SIDE_W-1:0]        side_o,
    input logic signed [ZW-1:0]     fold_z,
    input logic signed [ZW-1:0]     last_z
);
    import cordic_sine_pkg::*;

    localparam int QUARTER = 1 << (PHASE_W - 2 + ZG);
    localparam int RLIM    = resid_limit(PHASE_W, DATA_W);
    localparam logic [5:0] FULL = 6'(DATA_W + 2);
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W - 1){1'b0}}};

    logic [5:0] fill;

    // Count enabled edges since reset, saturating once the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (step_en && fill < FULL) begin
            fill <= fill + 6'd1;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(sine_o) && $stable(side_o)));

    // R5
    fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != 6'd0) |-> (fold_z >= -QUARTER && fold_z < QUARTER));

    // R11
    resid_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= FULL - 6'd1) |-> (last_z <= RLIM && last_z >= -RLIM));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FULL) |-> (sine_o != MIN_CODE));

endmodule

bind cordic_sine_core cordic_sine_core_chk #(
    .PHASE_W(PHASE_W), .DATA_W(DATA_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W), .ZW(ZW)
) i_chk (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .sine_o(sine_o),
    .side_o(side_o), .fold_z(fold_z), .last_z(last_z)
);

// File: tb/test_cordic_sine_core.sv
`timescale 1ns / 1ps
// Scoreboard bench: the driver pushes each accepted phase into three queues,
// and one monitor per build pops and compares on enabled edges.
module test_cordic_sine_core;

    localparam real TWO_PI = 6.283185307179586;
    localparam int  LAT_A = 18;
    localparam int  LAT_B = 16;
    localparam int  LAT_C = 18;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        step_en;
    logic [15:0] ph;
    logic [7:0]  sd;

    logic signed [15:0] sa;
    logic [7:0]         sda;
    logic signed [17:0] sb;
    logic [7:0]         sdb;
    logic signed [9:0]  sc;
    logic [7:0]         sdc;

    cordic_sine_core i_cordic_sine_core (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_i(ph), .side_i(sd),
        .sine_o(sa), .side_o(sda));

    cordic_sine_core #(.PHASE_W(12), .DATA_W(14), .OUT_W(18), .SIDE_W(8)) i_cordic_sine_core_b (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_i(ph[15:4]), .side_i(sd),
        .sine_o(sb), .side_o(sdb));

    cordic_sine_core #(.PHASE_W(16), .DATA_W(16), .OUT_W(10), .SIDE_W(8)) i_cordic_sine_core_c (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_i(ph), .side_i(sd),
        .sine_o(sc), .side_o(sdc));

    typedef struct {
        logic [15:0] ph;
        logic [7:0]  sd;
        string       rq;
    } item_t;

    item_t qa[$];
    item_t qb[$];
    item_t qc[$];
    item_t ia, ib, ic;

    int checks = 0;
    int errors = 0;
    int cnt_a = 0, cnt_b = 0, cnt_c = 0;
    bit edge_en = 1'b0;
    logic signed [15:0] last_a;
    logic signed [17:0] last_b;
    logic signed [9:0]  last_c;
    logic [7:0] last_sa, last_sb, last_sc;
    int seq = 0;
    logic [31:0] lcg = 32'h1234_5678;

    // Ideal sample from R4, clamped to the symmetric output range.
    function automatic real ideal(int pw, int dw, int ow, int p);
        real v, lim;
        v   = $sin(TWO_PI * real'(p) / (2.0 ** pw)) * (2.0 ** (dw - 1) - 1.0) * (2.0 ** (ow - dw));
        lim = 2.0 ** (ow - 1) - 1.0;
        if (v > lim) v = lim;
        if (v < -lim) v = -lim;
        return v;
    endfunction

    task automatic check_near(string rq, string what, real got, real exp, real tol);
        real d;
        checks++;
        d = got - exp;
        if (d < 0.0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s %s got %0f expected %0f", rq, what, got, exp);
        end
    endtask

    task automatic check_eq(string rq, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", rq, what, got, exp);
        end
    endtask

    // Record whether the pipeline stepped at this edge.
    always @(posedge clk) edge_en = step_en && rst_n;

    // Monitor for the default build (R2 R3 R4 R8 R10).
    always @(negedge clk) begin
        if (edge_en) begin
            cnt_a++;
            if (cnt_a >= LAT_A && qa.size() > 0) begin
                ia = qa.pop_front();
                check_near(ia.rq, "A sine", real'(sa), ideal(16, 16, 16, int'(ia.ph)), 6.0);
                check_eq("R2 R3", "A side", longint'(sda), longint'(ia.sd));
                if (sa == 16'sh8000) check_eq("R10", "A min code", longint'(sa), -32767);
            end
        end else if (rst_n && cnt_a >= LAT_A) begin
            check_eq("R8", "A hold sine", longint'(sa), longint'(last_a));
            check_eq("R8", "A hold side", longint'(sda), longint'(last_sa));
        end
        last_a  = sa;
        last_sa = sda;
    end

    // Monitor for the 12-bit phase, 14-bit core, 18-bit output build (R1 R7).
    always @(negedge clk) begin
        if (edge_en) begin
            cnt_b++;
            if (cnt_b >= LAT_B && qb.size() > 0) begin
                ib = qb.pop_front();
                check_near({"R1 ", ib.rq}, "B sine", real'(sb), ideal(12, 14, 18, int'(ib.ph >> 4)), 128.0);
                check_eq("R7", "B low bits", longint'(sb[3:0]), 0);
                check_eq("R2 R3", "B side", longint'(sdb), longint'(ib.sd));
            end
        end else if (rst_n && cnt_b >= LAT_B) begin
            check_eq("R8", "B hold sine", longint'(sb), longint'(last_b));
            check_eq("R8", "B hold side", longint'(sdb), longint'(last_sb));
        end
        last_b  = sb;
        last_sb = sdb;
    end

    // Monitor for the 10-bit rounded output build (R6).
    always @(negedge clk) begin
        if (edge_en) begin
            cnt_c++;
            if (cnt_c >= LAT_C && qc.size() > 0) begin
                ic = qc.pop_front();
                check_near("R6", "C rounded sine", real'(sc), ideal(16, 16, 10, int'(ic.ph)), 0.75);
                check_eq("R2 R3", "C side", longint'(sdc), longint'(ic.sd));
            end
        end else if (rst_n && cnt_c >= LAT_C) begin
            check_eq("R8", "C hold sine", longint'(sc), longint'(last_c));
        end
        last_c  = sc;
        last_sc = sdc;
    end

    // Present one phase for one enabled edge and queue its expectation.
    task automatic drive(logic [15:0] p, string rq);
        item_t it;
        @(posedge clk);
        #2;
        ph      = p;
        sd      = seq[7:0];
        seq++;
        step_en = 1'b1;
        it.ph = p;
        it.sd = sd;
        it.rq = rq;
        qa.push_back(it);
        qb.push_back(it);
        qc.push_back(it);
    endtask

    // Hold the enable low for n edges.
    task automatic stall(int n);
        @(posedge clk);
        #2;
        step_en = 1'b0;
        ph      = ~ph;
        sd      = ~sd;
        repeat (n - 1) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        step_en = 1'b0;
        ph      = '0;
        sd      = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: outputs cleared while reset is low
        check_eq("R9", "A reset sine", longint'(sa), 0);
        check_eq("R9", "A reset side", longint'(sda), 0);
        check_eq("R9", "B reset sine", longint'(sb), 0);
        check_eq("R9", "C reset sine", longint'(sc), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R5: quarter points and their neighbours
        drive(16'h0000, "R5"); drive(16'h4000, "R5"); drive(16'h8000, "R5");
        drive(16'hC000, "R5"); drive(16'h3FFF, "R5"); drive(16'h4001, "R5");
        drive(16'h7FFF, "R5"); drive(16'h8001, "R5"); drive(16'hBFFF, "R5");
        drive(16'hC001, "R5"); drive(16'hFFFF, "R5"); drive(16'h0001, "R5");
        drive(16'h2000, "R5"); drive(16'h6000, "R5"); drive(16'hA000, "R5");
        drive(16'hE000, "R5");

        // R4 with R8: pseudo-random phases with stall gaps
        for (int k = 0; k < 400; k++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            drive(lcg[23:8], "R4");
            if (k % 37 == 36) stall(3);
        end
        stall(5);

        // Flush the pipelines with unchecked enabled edges.
        @(posedge clk);
        #2;
        step_en = 1'b1;
        repeat (LAT_A + 4) @(posedge clk);
        #2;
        step_en = 1'b0;
        repeat (4) @(posedge clk);

        check_eq("R2", "A queue drained", longint'(qa.size()), 0);
        check_eq("R2", "B queue drained", longint'(qb.size()), 0);
        check_eq("R2", "C queue drained", longint'(qc.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule